// File: doc/BRIEF.md
# Cascadable Presettable Up/Down Counter

A fully synchronous binary counter, four bits wide by default, that steps up or down on each rising clock edge. It can be preset from a parallel data word, held by either of two active-low enables, and steered by a direction input. Every change of state happens at the clock edge. Load, enables and direction are sampled only there.

The block also produces an active-low ripple-carry. This signal is decoded without a register from three things: the present count, the second enable (T), and the live direction input. When counting up it marks the all-ones count, and when counting down it marks zero. Enable T gates the carry. Counters are chained into a wider synchronous counter as follows:

- The carry of each stage drives enable T of the next stage.
- Enable P, load and the clock are shared by all stages.

No extra gating is needed. A synchronous active-low reset clears the count to zero.

Top module: `casc_updown_counter`

## Requirements
- R1: While `load_n` is 0 at a rising edge, `count` takes the value of `din` after that edge, whatever the enables and `up_dn` are.
- R2: With `load_n`=1, `en_p_n`=0, `en_t_n`=0 and `up_dn`=1, each rising edge adds one to `count`, and the all-ones count wraps to 0.
- R3: With `load_n`=1, `en_p_n`=0, `en_t_n`=0 and `up_dn`=0, each rising edge subtracts one from `count`, and 0 wraps to all ones.
- R4: With `load_n`=1, `count` is unchanged by an edge at which `en_p_n` or `en_t_n` is 1.
- R5: Control inputs that change and return between edges have no effect on `count`. Only their values at the rising edge matter.
- R6: `carry_n` is 1 whenever `en_t_n` is 1.
- R7: With `en_t_n`=0, `carry_n` is 0 exactly when `count` is all ones with `up_dn`=1, or `count` is 0 with `up_dn`=0. Otherwise it is 1.
- R8: `carry_n` follows a change on `up_dn` with no clock edge. At count 0 it falls when the direction turns to down, and at all ones it falls when the direction turns to up.
- R9: With `rst_n`=0 at a rising edge, `count` is 0 after that edge. Reset takes priority over load.
- R10: Two stages form an 8-bit up/down counter when wired as follows, including across the 0xFF/0x00 and 0x0F/0x10 boundaries in both directions:
  - the low stage's `carry_n` drives the high stage's `en_t_n`;
  - `en_p_n`, `load_n` and `up_dn` are shared by both stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset, clears count |
| load_n | input | 1 | Active-low synchronous parallel preset |
| din | input | WIDTH | Preset value |
| en_p_n | input | 1 | Active-low count enable, not fed to the carry |
| en_t_n | input | 1 | Active-low count enable, also gates the carry |
| up_dn | input | 1 | 1 counts up, 0 counts down |
| count | output | WIDTH | Present count |
| carry_n | output | 1 | Active-low terminal-count carry, combinational |

## Verification
The assertions assume that all inputs are settled and free of X around each rising edge. They also assume reset has been applied at least once before the count is trusted, since the count register has no defined power-up value. The bench respects this by changing every input at the falling edge and applying reset first. Only the glitch test for R5 touches an input mid-cycle, and it restores the input well before the next rising edge. Carry checks are taken after a short settling delay following an input change, because `carry_n` is combinational.

// File: rtl/cnt_pkg.sv
// Shared types for the up/down counter.
package cnt_pkg;
    // Operation chosen for the coming clock edge.
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } cnt_op_e;
endpackage

// File: rtl/cnt_op_select.sv
// Chooses the operation for the next edge from the control inputs.
// Assumes inputs are stable around the edge. Load outranks counting.
module cnt_op_select
    import cnt_pkg::*;
(
    input  logic    load_n,
    input  logic    en_p_n,
    input  logic    en_t_n,
    input  logic    up_dn,
    output cnt_op_e op
);
    // Priority decode: load, then both enables low, else hold.
    always_comb begin
        if (!load_n)
            op = OP_LOAD;
        else if (!en_p_n && !en_t_n)
            op = up_dn ? OP_INC : OP_DEC;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/cnt_next_state.sv
// Computes the next count value for the chosen operation.
// Increment and decrement wrap modulo 2**WIDTH.
module cnt_next_state
    import cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Select the successor of the current count.
    always_comb begin
        unique case (op)
            OP_LOAD: nxt = din;
            OP_INC:  nxt = cur + ONE;
            OP_DEC:  nxt = cur - ONE;
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/cnt_terminal_detect.sv
// Active-low carry: flags the terminal count of the live direction.
// The output is gated by enable T. It is combinational on purpose, so a
// following stage sees it within the same clock cycle.
module cnt_terminal_detect #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             en_t_n,
    input  logic             up_dn,
    output logic             carry_n
);
    logic at_top;
    logic at_bottom;

    // Detect both ends of the count range.
    always_comb begin
        at_top    = &cur;
        at_bottom = ~|cur;
    end

    // Pick the end that matches the direction and gate it with enable T.
    always_comb begin
        carry_n = ~(~en_t_n & (up_dn ? at_top : at_bottom));
    end
endmodule

// File: rtl/casc_updown_counter.sv
// Synchronous presettable up/down counter with a look-ahead carry for
// chaining stages. Assumes inputs settle before each rising edge and that
// rst_n is pulsed once before the count is used.
module casc_updown_counter
    import cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             en_p_n,
    input  logic             en_t_n,
    input  logic             up_dn,
    output logic [WIDTH-1:0] count,
    output logic             carry_n
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ZERO     = '0;

    cnt_op_e          op;
    logic [WIDTH-1:0] nxt;
    logic [WIDTH-1:0] cnt_q;

    cnt_op_select u_sel (
        .load_n (load_n),
        .en_p_n (en_p_n),
        .en_t_n (en_t_n),
        .up_dn  (up_dn),
        .op     (op)
    );

    cnt_next_state #(.WIDTH(WIDTH)) u_nxt (
        .op  (op),
        .cur (cnt_q),
        .din (din),
        .nxt (nxt)
    );

    cnt_terminal_detect #(.WIDTH(WIDTH)) u_tc (
        .cur     (cnt_q),
        .en_t_n  (en_t_n),
        .up_dn   (up_dn),
        .carry_n (carry_n)
    );

    // Count register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= ZERO;
        else
            cnt_q <= nxt;
    end

    assign count = cnt_q;

    // Preset lands on the next edge regardless of enables (R1).
    p_load_copies_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> count == $past(din));

    // Up count steps by one with wrap (R2).
    p_up_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !en_p_n && !en_t_n && up_dn) |=> count == $past(count) + WIDTH'(1));

    // Down count steps by one with wrap (R3).
    p_down_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !en_p_n && !en_t_n && !up_dn) |=> count == $past(count) - WIDTH'(1));

    // Either enable high freezes the count (R4).
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && (en_p_n || en_t_n)) |=> $stable(count));

    // Carry stays inactive while enable T is high (R6).
    p_carry_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en_t_n |-> carry_n);

    // Carry is active at the terminal count of the live direction (R7).
    p_carry_term_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_t_n && ((up_dn && count == ALL_ONES) || (!up_dn && count == ZERO)))
            |-> !carry_n);
endmodule

// File: tb/casc_updown_counter_test.sv
module casc_updown_counter_test;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n, load_n, en_p_n, en_t_n, up_dn;
    logic [W-1:0] din;
    logic [W-1:0] count;
    logic         carry_n;

    // Cascade pair
    logic         c_rst_n, c_load_n, c_en_p_n, c_en_t_n, c_up_dn;
    logic [7:0]   c_din;
    logic [W-1:0] lo_q, hi_q;
    logic         lo_co, hi_co;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    casc_updown_counter #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
        .en_p_n(en_p_n), .en_t_n(en_t_n), .up_dn(up_dn),
        .count(count), .carry_n(carry_n)
    );

    casc_updown_counter #(.WIDTH(W)) lo_stage (
        .clk(clk), .rst_n(c_rst_n), .load_n(c_load_n), .din(c_din[3:0]),
        .en_p_n(c_en_p_n), .en_t_n(c_en_t_n), .up_dn(c_up_dn),
        .count(lo_q), .carry_n(lo_co)
    );

    casc_updown_counter #(.WIDTH(W)) hi_stage (
        .clk(clk), .rst_n(c_rst_n), .load_n(c_load_n), .din(c_din[7:4]),
        .en_p_n(c_en_p_n), .en_t_n(lo_co), .up_dn(c_up_dn),
        .count(hi_q), .carry_n(hi_co)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One rising edge, then sample at the following falling edge.
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_ctl(input logic ld, input logic [W-1:0] d,
                           input logic p, input logic t, input logic ud);
        load_n = ld; din = d; en_p_n = p; en_t_n = t; up_dn = ud;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        set_ctl(1'b0, 4'h7, 1'b1, 1'b1, 1'b1);  // load low too: reset wins
        tick();
        check(count == 0, "R9", count, 0);
        check(carry_n == 1'b1, "R6", carry_n, 1);
        rst_n = 1'b1;
    endtask

    task automatic t_load();
        set_ctl(1'b0, 4'hA, 1'b0, 1'b0, 1'b1);
        tick();
        check(count == 4'hA, "R1", count, 10);
        set_ctl(1'b0, 4'h3, 1'b1, 1'b1, 1'b0);
        tick();
        check(count == 4'h3, "R1", count, 3);
    endtask

    task automatic t_count_up();
        set_ctl(1'b0, 4'hD, 1'b0, 1'b0, 1'b1);
        tick();
        load_n = 1'b1;
        tick();
        check(count == 4'hE, "R2", count, 14);
        check(carry_n == 1'b1, "R7", carry_n, 1);
        tick();
        check(count == 4'hF, "R2", count, 15);
        check(carry_n == 1'b0, "R7", carry_n, 0);
        tick();
        check(count == 4'h0, "R2", count, 0);  // wrap
        check(carry_n == 1'b1, "R7", carry_n, 1);
    endtask

    task automatic t_count_down();
        set_ctl(1'b0, 4'h2, 1'b0, 1'b0, 1'b0);
        tick();
        load_n = 1'b1;
        tick();
        check(count == 4'h1, "R3", count, 1);
        check(carry_n == 1'b1, "R7", carry_n, 1);
        tick();
        check(count == 4'h0, "R3", count, 0);
        check(carry_n == 1'b0, "R7", carry_n, 0);
        tick();
        check(count == 4'hF, "R3", count, 15);  // wrap
    endtask

    task automatic t_hold();
        set_ctl(1'b0, 4'hF, 1'b1, 1'b0, 1'b1);
        tick();
        load_n = 1'b1;
        tick();
        check(count == 4'hF, "R4", count, 15);  // en_p high
        en_p_n = 1'b0; en_t_n = 1'b1;
        tick();
        check(count == 4'hF, "R4", count, 15);  // en_t high
        check(carry_n == 1'b1, "R6", carry_n, 1);
        en_t_n = 1'b0;
        #1;
        check(carry_n == 1'b0, "R6", carry_n, 0);
    endtask

    task automatic t_glitch();
        set_ctl(1'b0, 4'h5, 1'b1, 1'b1, 1'b1);
        tick();
        load_n = 1'b1;
        // Pulse controls mid-cycle, restored long before the next edge.
        din = 4'h9; load_n = 1'b0;
        #1 load_n = 1'b1;
        en_p_n = 1'b0; en_t_n = 1'b0;
        #1 en_p_n = 1'b1; en_t_n = 1'b1;
        tick();
        check(count == 4'h5, "R5", count, 5);
    endtask

    task automatic t_dir_carry();
        set_ctl(1'b0, 4'h0, 1'b1, 1'b0, 1'b1);
        tick();
        load_n = 1'b1;
        #1 check(carry_n == 1'b1, "R8", carry_n, 1);
        up_dn = 1'b0;
        #1 check(carry_n == 1'b0, "R8", carry_n, 0);
        tick();
        set_ctl(1'b0, 4'hF, 1'b1, 1'b0, 1'b0);
        tick();
        load_n = 1'b1;
        #1 check(carry_n == 1'b1, "R8", carry_n, 1);
        up_dn = 1'b1;
        #1 check(carry_n == 1'b0, "R8", carry_n, 0);
        tick();
    endtask

    task automatic run_cascade(input logic [7:0] start, input logic dir, input int steps);
        logic [7:0] exp_v;
        c_load_n = 1'b0; c_din = start; c_en_p_n = 1'b0; c_en_t_n = 1'b0; c_up_dn = dir;
        tick();
        check({hi_q, lo_q} == start, "R10", {hi_q, lo_q}, start);
        c_load_n = 1'b1;
        exp_v = start;
        for (int i = 0; i < steps; i++) begin
            tick();
            exp_v = dir ? exp_v + 8'd1 : exp_v - 8'd1;
            check({hi_q, lo_q} == exp_v, "R10", {hi_q, lo_q}, exp_v);
        end
    endtask

    task automatic t_cascade();
        c_rst_n = 1'b0;
        tick();
        c_rst_n = 1'b1;
        run_cascade(8'hFD, 1'b1, 4);   // through FF -> 00
        run_cascade(8'h0E, 1'b1, 3);   // through 0F -> 10
        run_cascade(8'h02, 1'b0, 4);   // through 00 -> FF
        run_cascade(8'h11, 1'b0, 3);   // through 10 -> 0F
        // Shared en_p high holds both stages.
        c_en_p_n = 1'b1;
        tick();
        check({hi_q, lo_q} == 8'h0E, "R10", {hi_q, lo_q}, 8'h0E);
    endtask

    initial begin
        c_rst_n = 1'b0; c_load_n = 1'b1; c_din = '0;
        c_en_p_n = 1'b1; c_en_t_n = 1'b1; c_up_dn = 1'b1;
        rst_n = 1'b0;
        set_ctl(1'b1, '0, 1'b1, 1'b1, 1'b1);
        tick();
        t_reset();
        t_load();
        t_count_up();
        t_count_down();
        t_hold();
        t_glitch();
        t_dir_carry();
        t_cascade();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule